// File: doc/BRIEF.md
# Packed SIMD Saturating Lane ALU

This block is an arithmetic and logic unit for 64-bit packed vectors. A 5-bit mode field selects the lane layout: eight unsigned byte lanes or four signed halfword lanes. The same field selects where the second operand comes from. It can be one lane of the second vector copied to every lane, the whole second vector taken lane by lane, or a 5-bit zero-extended immediate copied to every lane. The first operand is always the full first vector.

A 4-bit opcode picks one of fifteen lane operations: logic, shifts, saturating add, subtract and multiply, minimum and maximum, sign transfer, absolute difference and rounding average. Some opcodes exist for only one lane layout. An opcode that is not defined for the selected layout produces zero and raises a flag.

Each request is qualified by a valid strobe. The result, the valid flag and the flag are registered, so they appear one clock after the strobe.

Top module: `simd_lane_alu`

## Requirements
- R1: The lane layout is set by `fmtSel[0]`. A value of 0 gives eight unsigned 8-bit lanes, with lane i at bits 8i+7:8i. A value of 1 gives four signed 16-bit lanes, with lane i at bits 16i+15:16i.
- R2: The second operand is set by `fmtSel[4:3]`.
  - When `fmtSel[4]`=0, one lane of `opB` is copied to every lane. Its index is `fmtSel[3:2]` for halfwords and `fmtSel[3:1]` for bytes.
  - The value 2'b10 uses `opB` lane by lane.
  - The value 2'b11 copies `immVal`, zero-extended, to every lane.
- R3: Opcodes 0, 1, 2 and 3 give bitwise AND, NOR, OR and XOR in each lane.
- R4: Opcode 4 shifts left and opcode 5 shifts right logically. Opcode 12 shifts right arithmetically and exists for halfwords only. The shift amount is the low 4 bits of the second-operand lane for halfwords and the low 3 bits for bytes.
- R5: In halfword lanes, opcodes 6 (add), 7 (subtract) and 10 (multiply) clamp the signed result to the range -32768..32767.
- R6: In byte lanes, add (6) and multiply (10) clamp to 255, and subtract (7) clamps to 0.
- R7: Opcode 8 gives the minimum and opcode 9 the maximum. Halfword lanes compare as signed values and byte lanes as unsigned values.
- R8: Opcode 11 is sign transfer and exists for halfwords only.
  - If the first operand is negative, the result is the negated second operand, or 32767 when the second operand is -32768.
  - If the first operand is zero, the result is 0.
  - Otherwise the result is the second operand.
- R9: Opcodes 13 and 14 exist for bytes only. Opcode 13 gives the absolute difference. Opcode 14 gives (a+b+1)>>1, computed with a 9-bit sum.
- R10: An opcode not defined for the layout gives an all-zero result and `outIllegal`=1 in the same cycle as `outValid`. The undefined opcodes are 11, 12 and 15 for bytes and 13, 14 and 15 for halfwords.
- R11: `outResult`, `outValid` and `outIllegal` are registered and appear one cycle after `inValid`. With `inValid` low, `outValid` and `outIllegal` drop and `outResult` holds. Synchronous reset clears all three.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Request strobe |
| opA | input | 64 | First vector operand |
| opB | input | 64 | Second vector operand |
| immVal | input | 5 | Immediate for broadcast mode |
| fmtSel | input | 5 | Lane layout, operand source and lane index |
| opCode | input | 4 | Lane operation |
| outValid | output | 1 | Result valid, one cycle after inValid |
| outResult | output | 64 | Packed lane result |
| outIllegal | output | 1 | Opcode undefined for the selected layout |

## Verification
The hardest cases to reach from the ports are the saturation edges: a halfword multiply of -32768 by itself, sign transfer of -32768, and byte subtract crossing zero. Random operands rarely land exactly on these values. Directed cases place them in chosen lanes, combined with broadcast of the highest lane index and with shift amounts whose upper bits must be ignored. A fixed-seed random sweep over all modes and opcodes then covers the rest.

// File: rtl/simd_pkg.sv
package simd_pkg;
  localparam int VEC_W  = 64;
  localparam int BYTE_W = 8;
  localparam int HALF_W = 16;
  localparam int N_BYTE = VEC_W / BYTE_W;
  localparam int N_HALF = VEC_W / HALF_W;
  localparam int IMM_W  = 5;
  localparam int OP_W   = 4;

  typedef enum logic [1:0] {SRC_LANE = 2'd0, SRC_VEC = 2'd2, SRC_IMM = 2'd3} srcSel_e;

  typedef enum logic [OP_W-1:0] {
    OP_AND = 4'd0, OP_NOR = 4'd1, OP_OR = 4'd2, OP_XOR = 4'd3,
    OP_SHL = 4'd4, OP_SHR = 4'd5, OP_ADD = 4'd6, OP_SUB = 4'd7,
    OP_MIN = 4'd8, OP_MAX = 4'd9, OP_MUL = 4'd10, OP_SGN = 4'd11,
    OP_SRA = 4'd12, OP_ABD = 4'd13, OP_AVG = 4'd14, OP_NONE = 4'd15
  } aluOp_e;

  typedef struct packed {
    logic    fire;
    logic    half;
    srcSel_e src;
    logic [2:0] laneIdx;
    aluOp_e  op;
    logic    illegal;
  } ctrl_t;

  function automatic logic [BYTE_W-1:0] byteAlu(input aluOp_e op,
      input logic [BYTE_W-1:0] a, input logic [BYTE_W-1:0] b);
    logic [BYTE_W:0]     sum9;
    logic [2*BYTE_W-1:0] prod;
    sum9 = {1'b0, a} + {1'b0, b};
    prod = {{BYTE_W{1'b0}}, a} * {{BYTE_W{1'b0}}, b};
    case (op)
      OP_AND: return a & b;
      OP_NOR: return ~(a | b);
      OP_OR:  return a | b;
      OP_XOR: return a ^ b;
      OP_SHL: return a << b[2:0];
      OP_SHR: return a >> b[2:0];
      OP_ADD: return sum9[BYTE_W] ? {BYTE_W{1'b1}} : sum9[BYTE_W-1:0];
      OP_SUB: return (a >= b) ? a - b : '0;
      OP_MIN: return (a < b) ? a : b;
      OP_MAX: return (a > b) ? a : b;
      OP_MUL: return (|prod[2*BYTE_W-1:BYTE_W]) ? {BYTE_W{1'b1}} : prod[BYTE_W-1:0];
      OP_ABD: return (a >= b) ? a - b : b - a;
      OP_AVG: begin
        sum9 = sum9 + 9'd1;
        return sum9[BYTE_W:1];
      end
      default: return '0;
    endcase
  endfunction

  function automatic logic [HALF_W-1:0] clampHalf(input logic signed [31:0] v);
    if (v > 32'sd32767) return 16'h7fff;
    else if (v < -32'sd32768) return 16'h8000;
    else return v[HALF_W-1:0];
  endfunction

  function automatic logic [HALF_W-1:0] halfAlu(input aluOp_e op,
      input logic [HALF_W-1:0] a, input logic [HALF_W-1:0] b);
    logic signed [31:0] sa, sb;
    sa = 32'(signed'(a));
    sb = 32'(signed'(b));
    case (op)
      OP_AND: return a & b;
      OP_NOR: return ~(a | b);
      OP_OR:  return a | b;
      OP_XOR: return a ^ b;
      OP_SHL: return a << b[3:0];
      OP_SHR: return a >> b[3:0];
      OP_ADD: return clampHalf(sa + sb);
      OP_SUB: return clampHalf(sa - sb);
      OP_MIN: return (sa < sb) ? a : b;
      OP_MAX: return (sa > sb) ? a : b;
      OP_MUL: return clampHalf(sa * sb);
      OP_SGN: begin
        if (a[HALF_W-1]) return (b == 16'h8000) ? 16'h7fff : 16'(-b);
        else if (a == '0) return '0;
        else return b;
      end
      OP_SRA: return 16'($signed(a) >>> b[3:0]);
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/simd_ctrl.sv
module simd_ctrl
  import simd_pkg::*;
(
  input  logic             inValid,
  input  logic [4:0]       fmtSel,
  input  logic [OP_W-1:0]  opCode,
  output ctrl_t            ctrl
);
  logic half;
  assign half = fmtSel[0];

  always_comb begin
    ctrl.fire    = inValid;
    ctrl.half    = half;
    ctrl.src     = fmtSel[4] ? srcSel_e'({1'b1, fmtSel[3]}) : SRC_LANE;
    ctrl.laneIdx = half ? {1'b0, fmtSel[3:2]} : fmtSel[3:1];
    ctrl.op      = aluOp_e'(opCode);
    if (half) ctrl.illegal = (opCode == OP_ABD) || (opCode == OP_AVG) || (opCode == OP_NONE);
    else      ctrl.illegal = (opCode == OP_SGN) || (opCode == OP_SRA) || (opCode == OP_NONE);
  end
endmodule

// File: rtl/simd_dp.sv
module simd_dp
  import simd_pkg::*;
(
  input  ctrl_t              ctrl,
  input  logic [VEC_W-1:0]   opA,
  input  logic [VEC_W-1:0]   opB,
  input  logic [IMM_W-1:0]   immVal,
  output logic [VEC_W-1:0]   laneResult
);
  logic [VEC_W-1:0] byteRes, halfRes;
  logic [BYTE_W-1:0] byteBcast;
  logic [HALF_W-1:0] halfBcast;

  always_comb begin
    byteBcast = opB[ctrl.laneIdx*BYTE_W +: BYTE_W];
    halfBcast = opB[ctrl.laneIdx[1:0]*HALF_W +: HALF_W];
    if (ctrl.src == SRC_IMM) begin
      byteBcast = BYTE_W'(immVal);
      halfBcast = HALF_W'(immVal);
    end
  end

  for (genvar i = 0; i < N_BYTE; i++) begin : g_byte
    logic [BYTE_W-1:0] bOp;
    assign bOp = (ctrl.src == SRC_VEC) ? opB[i*BYTE_W +: BYTE_W] : byteBcast;
    assign byteRes[i*BYTE_W +: BYTE_W] = byteAlu(ctrl.op, opA[i*BYTE_W +: BYTE_W], bOp);
  end

  for (genvar i = 0; i < N_HALF; i++) begin : g_half
    logic [HALF_W-1:0] hOp;
    assign hOp = (ctrl.src == SRC_VEC) ? opB[i*HALF_W +: HALF_W] : halfBcast;
    assign halfRes[i*HALF_W +: HALF_W] = halfAlu(ctrl.op, opA[i*HALF_W +: HALF_W], hOp);
  end

  assign laneResult = ctrl.illegal ? '0 : (ctrl.half ? halfRes : byteRes);
endmodule

// File: rtl/simd_lane_alu.sv
module simd_lane_alu
  import simd_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               inValid,
  input  logic [VEC_W-1:0]   opA,
  input  logic [VEC_W-1:0]   opB,
  input  logic [IMM_W-1:0]   immVal,
  input  logic [4:0]         fmtSel,
  input  logic [OP_W-1:0]    opCode,
  output logic               outValid,
  output logic [VEC_W-1:0]   outResult,
  output logic               outIllegal
);
  ctrl_t ctrl;
  logic [VEC_W-1:0] laneResult;

  simd_ctrl u_ctrl (.inValid(inValid), .fmtSel(fmtSel), .opCode(opCode), .ctrl(ctrl));
  simd_dp   u_dp   (.ctrl(ctrl), .opA(opA), .opB(opB), .immVal(immVal), .laneResult(laneResult));

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid   <= 1'b0;
      outIllegal <= 1'b0;
      outResult  <= '0;
    end else begin
      outValid   <= ctrl.fire;
      outIllegal <= ctrl.fire & ctrl.illegal;
      if (ctrl.fire) outResult <= laneResult;
    end
  end

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid) else $error("valid latency"); // R11
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> (!outValid && $stable(outResult))) else $error("idle hold"); // R11
  AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (rst)
    outIllegal |-> (outValid && outResult == '0)) else $error("illegal zero"); // R10
  AST_BAD_OPCODE: assert property (@(posedge clk) disable iff (rst)
    (inValid && opCode == 4'd15) |=> outIllegal) else $error("opcode 15"); // R10

  for (genvar i = 0; i < N_BYTE; i++) begin : g_chk
    AST_BYTE_ADD_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
      (inValid && !fmtSel[0] && opCode == 4'd6) |=>
      (outResult[i*BYTE_W +: BYTE_W] >= $past(opA[i*BYTE_W +: BYTE_W])))
      else $error("byte add wrapped"); // R6
  end
endmodule

// File: tb/simd_lane_alu_tb.sv
module simd_lane_alu_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst = 1'b1, inValid = 1'b0;
  logic [63:0] opA = '0, opB = '0;
  logic [4:0] immVal = '0, fmtSel = '0;
  logic [3:0] opCode = '0;
  logic outValid, outIllegal;
  logic [63:0] outResult;

  int nChecks = 0, nErrors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  simd_lane_alu dut_i (.clk(clk), .rst(rst), .inValid(inValid), .opA(opA), .opB(opB),
    .immVal(immVal), .fmtSel(fmtSel), .opCode(opCode), .outValid(outValid),
    .outResult(outResult), .outIllegal(outIllegal));

  function automatic bit refIllegal(input logic [4:0] f, input logic [3:0] op);
    if (f[0]) return (op == 13) || (op == 14) || (op == 15);
    return (op == 11) || (op == 12) || (op == 15);
  endfunction

  function automatic int clampS(input longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return int'(v);
  endfunction

  function automatic logic [63:0] refAlu(input logic [63:0] a, input logic [63:0] b,
      input logic [4:0] imm, input logic [4:0] f, input logic [3:0] op);
    logic [63:0] r = '0;
    if (refIllegal(f, op)) return '0;
    if (f[0]) begin
      for (int i = 0; i < 4; i++) begin
        int x, y, z, s;
        logic [15:0] ub, ua;
        ua = a[16*i +: 16];
        if (!f[4]) ub = b[16*int'(f[3:2]) +: 16];
        else if (!f[3]) ub = b[16*i +: 16];
        else ub = {11'd0, imm};
        x = int'($signed(ua)); y = int'($signed(ub)); s = int'(ub[3:0]);
        case (op)
          0: z = int'(ua & ub);
          1: z = int'(~(ua | ub));
          2: z = int'(ua | ub);
          3: z = int'(ua ^ ub);
          4: z = (int'(ua) << s) & 65535;
          5: z = int'(ua) >> s;
          6: z = clampS(longint'(x) + y);
          7: z = clampS(longint'(x) - y);
          8: z = (x < y) ? x : y;
          9: z = (x > y) ? x : y;
          10: z = clampS(longint'(x) * y);
          11: z = (x < 0) ? ((y == -32768) ? 32767 : -y) : ((x == 0) ? 0 : y);
          default: z = x >>> s;
        endcase
        r[16*i +: 16] = z[15:0];
      end
    end else begin
      for (int i = 0; i < 8; i++) begin
        int x, y, z;
        x = int'(a[8*i +: 8]);
        if (!f[4]) y = int'(b[8*int'(f[3:1]) +: 8]);
        else if (!f[3]) y = int'(b[8*i +: 8]);
        else y = int'(imm);
        case (op)
          0: z = x & y;
          1: z = ~(x | y) & 255;
          2: z = x | y;
          3: z = x ^ y;
          4: z = (x << (y % 8)) & 255;
          5: z = x >> (y % 8);
          6: z = (x + y > 255) ? 255 : x + y;
          7: z = (x < y) ? 0 : x - y;
          8: z = (x < y) ? x : y;
          9: z = (x > y) ? x : y;
          10: z = (x * y > 255) ? 255 : x * y;
          13: z = (x > y) ? x - y : y - x;
          default: z = (x + y + 1) / 2;
        endcase
        r[8*i +: 8] = z[7:0];
      end
    end
    return r;
  endfunction

  function automatic string reqTag(input logic [4:0] f, input logic [3:0] op);
    if (refIllegal(f, op)) return "R10";
    case (op)
      0, 1, 2, 3: return "R3";
      4, 5, 12: return "R4";
      6, 7, 10: return f[0] ? "R5" : "R6";
      8, 9: return "R7";
      11: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic runOp(input logic [63:0] a, input logic [63:0] b, input logic [4:0] imm,
      input logic [4:0] f, input logic [3:0] op, input string extra);
    logic [63:0] exp;
    opA = a; opB = b; immVal = imm; fmtSel = f; opCode = op; inValid = 1'b1;
    exp = refAlu(a, b, imm, f, op);
    @(negedge clk);
    inValid = 1'b0;
    check({reqTag(f, op), extra}, outResult, exp);
    check("R11 valid", {63'd0, outValid}, 64'd1);
    check("R10 flag", {63'd0, outIllegal}, {63'd0, refIllegal(f, op)});
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    nErrors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

  initial begin
    logic [63:0] held;
    void'($urandom(1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R11 reset result", outResult, 64'd0);
    check("R11 reset valid", {63'd0, outValid}, 64'd0);
    check("R11 reset illegal", {63'd0, outIllegal}, 64'd0);

    // halfword saturation corners, vector mode (R5)
    runOp(64'h8000_8000_7fff_7fff, 64'h0001_8000_0001_7fff, 5'd0, 5'b10001, 4'd6, " add");
    runOp(64'h8000_8000_7fff_0000, 64'h0001_7fff_8000_8000, 5'd0, 5'b10001, 4'd7, " sub");
    runOp(64'h8000_0100_ff00_0003, 64'h8000_0100_0100_fffe, 5'd0, 5'b10001, 4'd10, " mul");
    // sign transfer corners (R8)
    runOp(64'hffff_0000_0005_fffe, 64'h8000_1234_8000_0007, 5'd0, 5'b10001, 4'd11, " sgn");
    // byte clamps (R6), abs/avg (R9)
    runOp(64'hff00_10ff_0102_8080, 64'h0101_1001_0203_8181, 5'd0, 5'b10000, 4'd6, " add");
    runOp(64'hff00_10ff_0102_8080, 64'h0101_1001_0203_8181, 5'd0, 5'b10000, 4'd7, " sub");
    runOp(64'hff00_10ff_0102_8080, 64'h0101_1001_0203_8181, 5'd0, 5'b10000, 4'd10, " mul");
    runOp(64'hff00_10ff_0102_8080, 64'hff01_1001_0203_8181, 5'd0, 5'b10000, 4'd14, " avg");
    runOp(64'hff00_10ff_0102_8080, 64'h00ff_1001_0203_8181, 5'd0, 5'b10000, 4'd13, " abd");
    // shift amount masking (R4), immediate and lane broadcast (R2)
    runOp(64'h8001_8001_8001_8001, 64'd0, 5'd17, 5'b11001, 4'd12, " sra imm R2");
    runOp(64'h0123_4567_89ab_cdef, 64'd0, 5'd9, 5'b11000, 4'd4, " shl imm R2");
    runOp(64'h0123_4567_89ab_cdef, 64'h0300_0000_0000_0000, 5'd0, 5'b01110, 4'd5, " lane7 R2");
    runOp(64'h8000_0001_7fff_ffff, 64'hfff0_0000_0000_0000, 5'd0, 5'b01101, 4'd8, " min lane3 R1");
    runOp(64'h8000_0001_7fff_ffff, 64'hfff0_0000_0000_0000, 5'd0, 5'b01100, 4'd9, " max byte R1");
    // illegal opcodes (R10)
    runOp(64'hffff_ffff_ffff_ffff, 64'h1, 5'd3, 5'b10000, 4'd11, "");
    runOp(64'hffff_ffff_ffff_ffff, 64'h1, 5'd3, 5'b10001, 4'd14, "");
    runOp(64'hffff_ffff_ffff_ffff, 64'h1, 5'd3, 5'b11001, 4'd15, "");
    // hold while idle (R11)
    runOp(64'h1111_2222_3333_4444, 64'h0, 5'd0, 5'b10000, 4'd2, "");
    held = outResult;
    opA = 64'hdead_beef_0000_ffff; opCode = 4'd1;
    @(negedge clk);
    check("R11 hold", outResult, held);
    check("R11 idle valid", {63'd0, outValid}, 64'd0);

    for (int n = 0; n < 600; n++) begin
      logic [63:0] a, b;
      a = {$urandom, $urandom};
      b = {$urandom, $urandom};
      if (n % 7 == 0) a[15:0] = 16'h8000;
      runOp(a, b, 5'($urandom), 5'($urandom), 4'($urandom), " rnd");
    end

    rst = 1'b1;
    @(negedge clk);
    check("R11 reset again", outResult, 64'd0);
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end
endmodule